// File: doc/BRIEF.md
# Biphase-Mark Audio Subframe Transmitter

This block turns PCM audio frames into a consumer digital-audio serial line coded in biphase mark. It runs from a clock at 128 times the sample rate, and each clock cycle emits one half-cell on the line. A frame is two subframes: channel A first, then channel B. Each subframe has 32 slots of two half-cells. The first four slots carry a sync pattern that breaks the coding rule on purpose. The remaining slots carry the audio word, a validity flag, a user bit, one channel-status bit and a parity bit.

Software first loads two 192-bit channel-status tables through a small word-wide write port, one table per channel. It then takes the block out of its two active-low soft resets, releasing the output side first and then the input side, and raises `enable`. Audio arrives one frame at a time over a valid/ready handshake. Digital mute works by marking every subframe invalid; the audio bits still go out unchanged.

Top module: `spdif_bmc_tx`

## Requirements
- R1: After `rst_n` is released with `enable` low, `line_out` is 0. With either soft reset low, `smp_ready` is 0.
- R2: A running frame lasts 128 cycles: a channel-A subframe, then a channel-B subframe. Each subframe opens with 8 sync half-cells. Taken in time order and following a line level of 0, these are 11101000 (block start), 11100010 (other channel-A subframes) or 11100100 (channel B). The block-start pattern appears on frame 0 after `enable` rises.
- R3: Every slot from 4 to 31 begins with a line transition. A slot holding a 1 has a second transition in its middle, and a slot holding a 0 has none.
- R4: Slots 4..27 carry the 24-bit audio word. Bit 0 is in slot 4 and the MSB is in slot 27, so the word goes out LSB first.
- R5: Slot 28 (validity) equals the `mute` level latched for that frame. Slot 29 (user) is always 0.
- R6: Slot 30 of frame n carries bit n of the channel's status table. Write address w in 0..5 loads table A bits 32w+31..32w, and address 6+w loads the same bits of table B. Writes to addresses 12..15 change nothing.
- R7: Slot 31 makes the count of ones over slots 4..31 even.
- R8: The status-bit index advances once per frame and wraps from 191 to 0. Frame 192 therefore carries the block-start sync again, together with status bit 0.
- R9: `chan_mask` 11 sends `smp_a` in subframe A and `smp_b` in subframe B. Mask 01 sends `smp_a` in both subframes and ignores `smp_b`. Mask 00 keeps `smp_ready` at 0.
- R10: The input side stays in reset while `out_rst_n` is low, even if `in_rst_n` is high. `smp_ready` can only rise once both soft resets are high, and the line runs only when both are high and `enable` is high.
- R11: When `enable` falls, `line_out` reads 0 from the next cycle onward. A later restart begins again at status index 0 with the block-start sync.
- R12: One sample frame is held ahead of the serializer. Once a frame is accepted, `smp_ready` stays low until that frame starts transmitting. Frame j on the line carries the j-th accepted sample frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, 128 x sample rate |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| out_rst_n | input | 1 | Active-low soft reset of the serializer side |
| in_rst_n | input | 1 | Active-low soft reset of the sample input side |
| enable | input | 1 | Runs the serial stream while high |
| mute | input | 1 | Marks transmitted subframes as invalid |
| chan_mask | input | 2 | Channel pull mask (01 mono, 11 stereo) |
| wr_en | input | 1 | Status table write strobe |
| wr_addr | input | 4 | Status word address (0..5 table A, 6..11 table B) |
| wr_data | input | 32 | Status word value |
| smp_valid | input | 1 | Sample frame offered |
| smp_ready | output | 1 | Sample frame accepted on this edge when valid |
| smp_a | input | 24 | Channel A audio word |
| smp_b | input | 24 | Channel B audio word |
| line_out | output | 1 | Biphase-mark coded serial output |

## Verification
The hardest case to reach from the ports is the wrap of the status index. It only shows at frame 192, which is more than 24,000 cycles into a single unbroken stream. The bench holds the handshake saturated in mono mode for 194 frames without a break. A decoder recovers every subframe from the raw half-cells and compares it with a queue of subframes predicted from the bench's own copy of the status tables. Mute is latched per frame, so the stimulus changes it right after each sample is accepted. A stop followed by a new reset-release sequence then shows that the index restarts at zero.

// File: rtl/spdif_tx_pkg.sv
// Package: shared constants and sync-pattern lookup for the biphase-mark
// transmitter. Assumes the 32-slot subframe of the consumer audio line.
package spdif_tx_pkg;

    localparam int SLOTS        = 32;
    localparam int HALVES_SUB   = 2 * SLOTS;
    localparam int HALVES_FRAME = 2 * HALVES_SUB;
    localparam int HC_W         = $clog2(HALVES_FRAME);
    localparam int AUDIO_TOP    = 27;
    localparam int FIRST_DATA   = 4;

    typedef enum logic [1:0] {
        SYNC_NONE  = 2'd0,
        SYNC_BLOCK = 2'd1,
        SYNC_CHA   = 2'd2,
        SYNC_CHB   = 2'd3
    } sync_e;

    // Sync half-cells, bit 7 sent first, valid after a line level of 0.
    function automatic logic [7:0] sync_bits(sync_e kind);
        case (kind)
            SYNC_BLOCK: sync_bits = 8'b1110_1000;
            SYNC_CHA:   sync_bits = 8'b1110_0010;
            SYNC_CHB:   sync_bits = 8'b1110_0100;
            default:    sync_bits = 8'b0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/spdif_status_bank.sv
// Module: two channel-status tables (A and B), each CS_BITS wide, kept as
// 32-bit words. Word w of table A sits at address w, and word w of table B
// at address w + CS_BITS/32. Addresses past the last word are ignored.
// Reads are combinational, one bit per table at a shared index.
// Assumes CS_BITS is a multiple of 32 and at least 64.
module spdif_status_bank #(
    parameter int CS_BITS = 192,
    localparam int WORDS  = CS_BITS / 32,
    localparam int ADDR_W = $clog2(2 * WORDS),
    localparam int IDX_W  = $clog2(CS_BITS),
    localparam int WSEL_W = IDX_W - 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              cs_a,
    output logic              cs_b
);

    logic [31:0] word_a [WORDS];
    logic [31:0] word_b [WORDS];

    // Load the addressed status word; out-of-range addresses match nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                word_a[w] <= '0;
                word_b[w] <= '0;
            end
        end else if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_addr == ADDR_W'(w))         word_a[w] <= wr_data;
                if (wr_addr == ADDR_W'(w + WORDS)) word_b[w] <= wr_data;
            end
        end
    end

    // Select the status bit for the current frame from both tables.
    always_comb begin
        cs_a = word_a[rd_idx[IDX_W-1 -: WSEL_W]][rd_idx[4:0]];
        cs_b = word_b[rd_idx[IDX_W-1 -: WSEL_W]][rd_idx[4:0]];
    end

endmodule

// File: rtl/spdif_sample_hold.sv
// Module: input side. Holds one sample frame ahead of the serializer and
// runs the valid/ready handshake. The side stays in reset while either soft
// reset is low, so the serializer side must leave reset first.
// Assumes `consume` pulses only at the start of a frame that used the hold.
module spdif_sample_hold #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_rst_n,
    input  logic                out_rst_n,
    input  logic [1:0]          chan_mask,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_a,
    input  logic [SAMPLE_W-1:0] smp_b,
    output logic                smp_ready,
    input  logic                consume,
    output logic                hold_full,
    output logic [SAMPLE_W-1:0] hold_a,
    output logic [SAMPLE_W-1:0] hold_b
);

    logic in_live;
    logic accept;

    // Input side is live only after both soft resets are released.
    always_comb begin
        in_live   = in_rst_n && out_rst_n;
        smp_ready = in_live && (chan_mask != 2'b00) && !hold_full;
        accept    = smp_valid && smp_ready;
    end

    // Capture a frame into the hold; mono copies A into the B slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_live) begin
            hold_full <= 1'b0;
            hold_a    <= '0;
            hold_b    <= '0;
        end else if (accept) begin
            hold_full <= 1'b1;
            hold_a    <= chan_mask[0] ? smp_a : '0;
            hold_b    <= chan_mask[1] ? smp_b : (chan_mask[0] ? smp_a : '0);
        end else if (consume) begin
            hold_full <= 1'b0;
        end
    end

    AST_HOLD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> hold_full); // R12
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !consume && in_rst_n && out_rst_n) |=> (hold_full && $stable(hold_a) && $stable(hold_b))); // R12
    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rst_n || !out_rst_n) |=> !hold_full); // R10

endmodule

// File: rtl/spdif_frame_seq.sv
// Module: half-cell and frame counters. The half-cell counter walks 0..127
// through one frame, and the frame index walks 0..CS_BITS-1 and wraps.
// Both stay at zero while the stream is stopped.
module spdif_frame_seq
    import spdif_tx_pkg::*;
#(
    parameter int CS_BITS = 192,
    localparam int IDX_W  = $clog2(CS_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [HC_W-1:0]  hc,
    output logic [IDX_W-1:0] fidx,
    output logic             frame_end
);

    localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HALVES_FRAME - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CS_BITS - 1);

    // Last half-cell of a running frame.
    always_comb frame_end = run && (hc == HC_LAST);

    // Advance the half-cell counter and step the frame index at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hc   <= '0;
            fidx <= '0;
        end else begin
            hc <= hc + 1'b1;
            if (frame_end) fidx <= (fidx == IDX_LAST) ? '0 : fidx + 1'b1;
        end
    end

    AST_HC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hc != HC_LAST) |=> (hc == HC_W'($past(hc) + 1'b1))); // R2
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hc == HC_LAST && fidx == IDX_LAST) |=> (fidx == '0)); // R8
    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hc == '0 && fidx == '0)); // R11

endmodule

// File: rtl/spdif_bmc_encoder.sv
// Module: builds the 32-slot subframe word for the current half-cell and
// drives the biphase-mark line. Sync slots come from a fixed pattern, and
// the pattern is inverted if the line sat at 1 before the subframe.
// Assumes the frame fields stay stable across the frame.
module spdif_bmc_encoder
    import spdif_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [HC_W-1:0]     hc,
    input  logic                block_start,
    input  logic [SAMPLE_W-1:0] aud_a,
    input  logic [SAMPLE_W-1:0] aud_b,
    input  logic                vflag,
    input  logic                cs_a,
    input  logic                cs_b,
    output logic                line_out
);

    logic        chan_b;
    logic [4:0]  slot;
    logic        half;
    sync_e       kind;
    logic [31:0] word;
    logic [7:0]  pat;
    logic        pre_ref_q;
    logic        pre_ref;
    logic        nxt;

    // Split the half-cell count into channel, slot and half.
    always_comb begin
        chan_b = hc[HC_W-1];
        slot   = hc[HC_W-2:1];
        half   = hc[0];
        kind   = chan_b ? SYNC_CHB : (block_start ? SYNC_BLOCK : SYNC_CHA);
        pat    = sync_bits(kind);
    end

    // Assemble the subframe word: audio, validity, user, status, parity.
    always_comb begin
        word = '0;
        word[AUDIO_TOP -: SAMPLE_W] = chan_b ? aud_b : aud_a;
        word[28] = vflag;
        word[29] = 1'b0;
        word[30] = chan_b ? cs_b : cs_a;
        word[31] = ^word[30:FIRST_DATA];
    end

    // Choose the next line level from the sync pattern or the data rule.
    always_comb begin
        pre_ref = (hc[HC_W-2:0] == '0) ? line_out : pre_ref_q;
        if (slot < 5'(FIRST_DATA))
            nxt = pat[3'd7 - {slot[1:0], half}] ^ pre_ref;
        else if (!half)
            nxt = !line_out;
        else
            nxt = word[slot] ? !line_out : line_out;
    end

    // Register the line and keep the pre-subframe level for the sync slots.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            line_out  <= 1'b0;
            pre_ref_q <= 1'b0;
        end else begin
            line_out <= nxt;
            if (hc[HC_W-2:0] == '0) pre_ref_q <= line_out;
        end
    end

    AST_SLOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot >= 5'(FIRST_DATA) && !half) |=> (line_out != $past(line_out))); // R3
    AST_SYNC_LEAD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hc[HC_W-2:0] == '0) |=> (line_out != $past(line_out))); // R2

endmodule

// File: rtl/spdif_bmc_tx.sv
// Module: top of the biphase-mark audio transmitter. Connects the status
// tables, the sample hold, the frame counters and the line encoder, and
// owns the per-frame register that freezes audio and mute for one frame.
// Assumes clk runs at 128 times the sample rate.
module spdif_bmc_tx
    import spdif_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CS_BITS  = 192
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             out_rst_n,
    input  logic                             in_rst_n,
    input  logic                             enable,
    input  logic                             mute,
    input  logic [1:0]                       chan_mask,
    input  logic                             wr_en,
    input  logic [$clog2(CS_BITS/16)-1:0]    wr_addr,
    input  logic [31:0]                      wr_data,
    input  logic                             smp_valid,
    output logic                             smp_ready,
    input  logic [SAMPLE_W-1:0]              smp_a,
    input  logic [SAMPLE_W-1:0]              smp_b,
    output logic                             line_out
);

    localparam int IDX_W = $clog2(CS_BITS);

    logic                run;
    logic [HC_W-1:0]     hc;
    logic [IDX_W-1:0]    fidx;
    logic                frame_end;
    logic                cs_a;
    logic                cs_b;
    logic                hold_full;
    logic [SAMPLE_W-1:0] hold_a;
    logic [SAMPLE_W-1:0] hold_b;
    logic                consume;
    logic [SAMPLE_W-1:0] fr_a;
    logic [SAMPLE_W-1:0] fr_b;
    logic                fr_v;
    logic                fr_has;

    // The stream runs only with both soft resets released and enable high.
    always_comb begin
        run     = enable && out_rst_n && in_rst_n;
        consume = run && (hc == '0) && fr_has;
    end

    // Freeze the next frame's audio and mute, tracking the hold while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_a   <= '0;
            fr_b   <= '0;
            fr_v   <= 1'b0;
            fr_has <= 1'b0;
        end else if (!run || frame_end) begin
            fr_a   <= hold_full ? hold_a : '0;
            fr_b   <= hold_full ? hold_b : '0;
            fr_v   <= mute;
            fr_has <= hold_full;
        end
    end

    spdif_status_bank #(.CS_BITS(CS_BITS)) i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (fidx),
        .cs_a    (cs_a),
        .cs_b    (cs_b)
    );

    spdif_sample_hold #(.SAMPLE_W(SAMPLE_W)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_rst_n  (in_rst_n),
        .out_rst_n (out_rst_n),
        .chan_mask (chan_mask),
        .smp_valid (smp_valid),
        .smp_a     (smp_a),
        .smp_b     (smp_b),
        .smp_ready (smp_ready),
        .consume   (consume),
        .hold_full (hold_full),
        .hold_a    (hold_a),
        .hold_b    (hold_b)
    );

    spdif_frame_seq #(.CS_BITS(CS_BITS)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hc        (hc),
        .fidx      (fidx),
        .frame_end (frame_end)
    );

    spdif_bmc_encoder #(.SAMPLE_W(SAMPLE_W)) i_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .hc          (hc),
        .block_start (fidx == '0),
        .aud_a       (fr_a),
        .aud_b       (fr_b),
        .vflag       (fr_v),
        .cs_a        (cs_a),
        .cs_b        (cs_b),
        .line_out    (line_out)
    );

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && out_rst_n && in_rst_n) |=> !line_out); // R11
    AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mask == 2'b00) |-> !smp_ready); // R9

endmodule

// File: tb/test_spdif_bmc_tx.sv
module test_spdif_bmc_tx;

    localparam int SW = 24;

    typedef struct packed {
        logic [1:0]  sync;   // 1 block start, 2 channel A, 3 channel B
        logic [27:0] body;   // body[k] is slot 4+k
    } sub_t;

    logic        clk = 1'b0;
    logic        rst_n, out_rst_n, in_rst_n, enable, mute;
    logic [1:0]  chan_mask;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic        smp_valid, smp_ready;
    logic [SW-1:0] smp_a, smp_b;
    logic        line_out;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [191:0] ref_a, ref_b;
    sub_t exp_q[$];
    int   phase = 0;

    always #2 clk = ~clk;

    spdif_bmc_tx i_spdif_bmc_tx (
        .clk(clk), .rst_n(rst_n), .out_rst_n(out_rst_n), .in_rst_n(in_rst_n),
        .enable(enable), .mute(mute), .chan_mask(chan_mask), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_a(smp_a), .smp_b(smp_b), .line_out(line_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] pat_a(int j);
        return SW'(32'h00A5_3C01 * (j + 3));
    endfunction
    function automatic logic [SW-1:0] pat_b(int j);
        return SW'(32'h0013_579B * (j + 7));
    endfunction

    function automatic sub_t mk_sub(logic [1:0] s, logic [SW-1:0] aud, logic v, logic c);
        sub_t r;
        r.sync = s;
        r.body = '0;
        r.body[23:0] = aud;
        r.body[24] = v;
        r.body[25] = 1'b0;
        r.body[26] = c;
        r.body[27] = ^r.body[26:0];
        return r;
    endfunction

    task automatic write_word(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: offers n frames, predicts the subframes, starts the stream.
    task automatic drive(input int n, input logic [1:0] mask, input int mmode);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            smp_a = pat_a(j); smp_b = pat_b(j); smp_valid = 1'b1;
            while (!smp_ready) @(negedge clk);
            @(posedge clk);
            begin
                logic m;
                m = (mmode == 0) ? logic'(j % 2) : logic'(j == 5);
                exp_q.push_back(mk_sub((j % 192 == 0) ? 2'd1 : 2'd2, pat_a(j), m, ref_a[j % 192]));
                exp_q.push_back(mk_sub(2'd3, mask[1] ? pat_b(j) : pat_a(j), m, ref_b[j % 192]));
                @(negedge clk);
                mute = m;
                smp_valid = 1'b0;
                if (j == 0) begin
                    check(smp_ready == 1'b0, "R12", "ready low while hold full", smp_ready, 0);
                    repeat (2) @(negedge clk);
                    enable = 1'b1;
                end
            end
        end
        smp_valid = 1'b0;
    endtask

    // Monitor: decodes subframes from raw half-cells and compares with the queue.
    task automatic capture(input int nsub, input bit mono);
        logic [63:0] hv;
        logic        lvl_prev;
        int          waited;
        waited = 0;
        lvl_prev = 1'b0;
        @(negedge clk);
        while (line_out !== 1'b1 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        check(line_out === 1'b1, "R2", "stream start seen", line_out, 1);
        for (int s = 0; s < nsub; s++) begin
            logic [7:0]  sb;
            logic [1:0]  code;
            logic [27:0] body;
            bit          edges_ok;
            sub_t        e;
            int          j;
            string       sreq;
            j = s / 2;
            for (int i = 0; i < 64; i++) begin
                if (!(s == 0 && i == 0)) @(negedge clk);
                hv[i] = line_out;
            end
            for (int i = 0; i < 8; i++) sb[7-i] = hv[i] ^ lvl_prev;
            code = (sb == 8'b1110_1000) ? 2'd1 : (sb == 8'b1110_0010) ? 2'd2 :
                   (sb == 8'b1110_0100) ? 2'd3 : 2'd0;
            edges_ok = 1;
            for (int k = 0; k < 28; k++) begin
                int sl;
                sl = 4 + k;
                if (hv[2*sl] == hv[2*sl-1]) edges_ok = 0;
                body[k] = hv[2*sl] ^ hv[2*sl+1];
            end
            lvl_prev = hv[63];
            check(edges_ok, "R3", "slot boundary transitions", 0, 0);
            if (exp_q.size() == 0) begin
                check(0, "R12", "unexpected subframe", s, 0);
            end else begin
                e = exp_q.pop_front();
                if (j == 192 && s % 2 == 0)                   sreq = "R8";
                else if (phase == 2 && s == 0)                sreq = "R11";
                else                                          sreq = "R2";
                check(code == e.sync, sreq, "sync pattern", code, e.sync);
                check(body[23:0] == e.body[23:0], (mono && s % 2 == 1) ? "R9" : "R4",
                      "audio word", body[23:0], e.body[23:0]);
                check(body[25:24] == e.body[25:24], "R5", "validity/user", body[25:24], e.body[25:24]);
                check(body[26] == e.body[26], (j == 192) ? "R8" : "R6", "status bit", body[26], e.body[26]);
                check(body[27] == e.body[27], "R7", "parity", body[27], e.body[27]);
            end
        end
    endtask

    task automatic start_sequence();
        @(negedge clk);
        enable = 1'b0; out_rst_n = 1'b0; in_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        out_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        in_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop_and_check();
        @(negedge clk);
        enable = 1'b0;
        begin
            bit quiet;
            quiet = 1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (line_out !== 1'b0) quiet = 0;
            end
            check(quiet, "R11", "line quiet after enable falls", line_out, 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; out_rst_n = 0; in_rst_n = 0; enable = 0; mute = 0;
        chan_mask = 2'b11; wr_en = 0; wr_addr = '0; wr_data = '0;
        smp_valid = 0; smp_a = '0; smp_b = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(line_out == 1'b0, "R1", "line after reset", line_out, 0);
        check(smp_ready == 1'b0, "R1", "ready with soft resets low", smp_ready, 0);

        // Status tables (R6), then junk at unused addresses
        for (int w = 0; w < 6; w++) begin
            logic [31:0] va, vb;
            va = 32'h9E37_79B9 * (w + 1);
            vb = 32'h7F4A_7C15 ^ (w * 32'h0101_0101);
            ref_a[w*32 +: 32] = va;
            ref_b[w*32 +: 32] = vb;
            write_word(w, va);
            write_word(w + 6, vb);
        end
        write_word(12, 32'hFFFF_FFFF);
        write_word(15, 32'hFFFF_FFFF);

        // R10: input reset released first has no effect
        in_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(smp_ready == 1'b0, "R10", "ready while output reset held", smp_ready, 0);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        check(line_out == 1'b0, "R10", "line while output reset held", line_out, 0);
        enable = 1'b0;
        out_rst_n = 1'b1;
        @(negedge clk);
        check(smp_ready == 1'b1, "R10", "ready after both resets released", smp_ready, 1);
        chan_mask = 2'b00;
        @(negedge clk);
        check(smp_ready == 1'b0, "R9", "ready with empty mask", smp_ready, 0);
        check(line_out == 1'b0, "R1", "line idle with enable low", line_out, 0);

        // Phase 1: stereo, alternating mute
        phase = 1;
        start_sequence();
        chan_mask = 2'b11;
        fork
            drive(6, 2'b11, 0);
            capture(12, 0);
        join
        stop_and_check();

        // Phase 2: mono across the status wrap, restart from index 0
        phase = 2;
        start_sequence();
        chan_mask = 2'b01;
        exp_q.delete();
        fork
            drive(194, 2'b01, 1);
            capture(388, 1);
        join
        stop_and_check();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule